// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block arbitrates interrupt service for a small processor core. Requests arrive on one line per priority level, already masked by their sources. They are captured into a pending register at instruction-cycle boundaries, except in cycles that carry an I/O instruction. A software write port can also set pending bits directly. A second register records which levels are currently in service. When the global enable flag is set, the controller picks the highest-numbered pending level that is not yet in service. If that level is above every level in service, the controller accepts it: it raises a one-cycle acknowledge carrying the 3-bit level, marks the level active and clears the enable flag.

The core reports its control instructions on a small command port: disable, enable, return-from-interrupt and sleep. A return retires the highest active level by clearing both its pending bit and its active bit, and it sets the enable flag again. Because pending and active are kept apart, service routines nest: a higher level can preempt a lower one that is in service, while a lower or equal level waits. A status output shows when nothing is pending and nothing is active. That is the only condition under which the core may enter sleep.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the enable flag, the pending register and the active register are all zero, `ack_valid` is low and `sleep_ok` is high.
- R2: On a clock edge where `cyc_strobe`=1 and `cyc_is_io`=0, every set bit of `hw_req` sets the pending bit of the same index. A request seen with `cyc_strobe`=0, or with `cyc_is_io`=1, leaves the pending register unchanged.
- R3: On a clock edge with `swi_we`=1, every set bit of `swi_bits` sets the same pending bit, whatever the strobe. Such a bit is then arbitrated exactly like a hardware request.
- R4: Consider a cycle where the enable flag is 1 and `cmd_valid`=0. Let L be the highest-numbered bit of pending AND NOT active. If L is above every active level, or if nothing is active, then in the next cycle `ack_valid` is 1 for exactly one cycle with `ack_level`=L, active bit L is set and the enable flag is 0.
- R5: A pending level that is not above the highest active level is not acknowledged while that active level remains.
- R6: While the enable flag is 0, requests are still recorded in the pending register and no acknowledge is produced.
- R7: A return command (`cmd_op`=2) clears the pending bit and the active bit of the highest active level and sets the enable flag.
- R8: With `cmd_valid`=1, `cmd_op`=0 (disable) clears the enable flag, while `cmd_op`=1 (enable) and `cmd_op`=3 (sleep) set it.
- R9: A request for a level whose pending bit is already set has no further effect: the level is acknowledged only once, until its return clears the bit.
- R10: When a request for a level is sampled in the same cycle as the return that retires that level, the pending bit stays set and the level is acknowledged again.
- R11: `sleep_ok` is 1 exactly when both the pending register and the active register are zero.
- R12: No acknowledge is started on a clock edge where `cmd_valid`=1. Acceptance waits for the first cycle without a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| cyc_strobe | input | 1 | Instruction-cycle boundary, the request sampling point |
| cyc_is_io | input | 1 | The current cycle is an I/O instruction; it suppresses sampling |
| hw_req | input | 8 | Masked hardware request per level |
| swi_we | input | 1 | Software interrupt write strobe |
| swi_bits | input | 8 | Pending bits to set by software |
| cmd_valid | input | 1 | A control command is present |
| cmd_op | input | 2 | 0 disable, 1 enable, 2 return, 3 sleep |
| ack_valid | output | 1 | One-cycle interrupt acknowledge |
| ack_level | output | 3 | Level being acknowledged |
| irq_en | output | 1 | Global enable flag |
| pending | output | 8 | Pending register |
| active | output | 8 | Active register |
| sleep_ok | output | 1 | Nothing pending and nothing active |

## Verification
Two functions can act on the same pending bit in one cycle: the sampling of a fresh request and its retirement by a return. The bench provokes this by raising the request on the strobe edge that carries the return for that same level. It then checks that the bit survives, that the active bit clears and that a second acknowledge for the level follows. A second collision puts a command in every cycle in which an acceptance would otherwise fire; the bench checks that the acknowledge appears only once the command port is idle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   typedef enum logic [1:0] {
      CMD_DISABLE = 2'd0,
      CMD_ENABLE  = 2'd1,
      CMD_RETURN  = 2'd2,
      CMD_SLEEP   = 2'd3
   } irq_cmd_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int NUM_LEVELS = 8,
   localparam int LVL_W = $clog2(NUM_LEVELS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sample_en,
   input  logic [NUM_LEVELS-1:0] hw_req,
   input  logic                  swi_we,
   input  logic [NUM_LEVELS-1:0] swi_bits,
   input  logic                  clr_en,
   input  logic [LVL_W-1:0]      clr_lvl,
   output logic [NUM_LEVELS-1:0] pend_q
);
   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_bit
      logic set_i;
      logic clr_i;
      assign set_i = (sample_en & hw_req[i]) | (swi_we & swi_bits[i]);
      assign clr_i = clr_en && (clr_lvl == LVL_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     pend_q[i] <= 1'b0;
         else if (set_i) pend_q[i] <= 1'b1;
         else if (clr_i) pend_q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_LEVELS = 8,
   localparam int LVL_W = $clog2(NUM_LEVELS)
) (
   input  logic [NUM_LEVELS-1:0] vec,
   output logic                  any,
   output logic [LVL_W-1:0]      top
);
   logic [LVL_W-1:0] idx_chain [NUM_LEVELS+1];
   assign idx_chain[0] = '0;
   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_scan
      assign idx_chain[i+1] = vec[i] ? LVL_W'(i) : idx_chain[i];
   end
   assign top = idx_chain[NUM_LEVELS];
   assign any = |vec;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int NUM_LEVELS = 8,
   localparam int LVL_W = $clog2(NUM_LEVELS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cyc_strobe,
   input  logic                  cyc_is_io,
   input  logic [NUM_LEVELS-1:0] hw_req,
   input  logic                  swi_we,
   input  logic [NUM_LEVELS-1:0] swi_bits,
   input  logic                  cmd_valid,
   input  logic [1:0]            cmd_op,
   output logic                  ack_valid,
   output logic [LVL_W-1:0]      ack_level,
   output logic                  irq_en,
   output logic [NUM_LEVELS-1:0] pending,
   output logic [NUM_LEVELS-1:0] active,
   output logic                  sleep_ok
);
   import irq_prio_pkg::*;

   initial begin
      assert (NUM_LEVELS >= 2 && NUM_LEVELS <= 32)
         else $error("NUM_LEVELS out of supported range");
      assert ((1 << LVL_W) == NUM_LEVELS)
         else $error("NUM_LEVELS must be a power of two");
   end

   irq_cmd_e         cmd;
   logic             do_ret;
   logic             sample_en;
   logic             cand_any;
   logic [LVL_W-1:0] cand_lvl;
   logic             act_any;
   logic [LVL_W-1:0] act_top;
   logic             accept;
   logic             en_q;
   logic [NUM_LEVELS-1:0] act_q;
   logic [NUM_LEVELS-1:0] pend_q;

   assign cmd       = irq_cmd_e'(cmd_op);
   assign do_ret    = cmd_valid && (cmd == CMD_RETURN);
   assign sample_en = cyc_strobe & ~cyc_is_io;

   irq_pend_reg #(.NUM_LEVELS(NUM_LEVELS)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_en(sample_en),
      .hw_req   (hw_req),
      .swi_we   (swi_we),
      .swi_bits (swi_bits),
      .clr_en   (do_ret && act_any),
      .clr_lvl  (act_top),
      .pend_q   (pend_q)
   );

   irq_prio_enc #(.NUM_LEVELS(NUM_LEVELS)) u_cand (
      .vec(pend_q & ~act_q),
      .any(cand_any),
      .top(cand_lvl)
   );

   irq_prio_enc #(.NUM_LEVELS(NUM_LEVELS)) u_act (
      .vec(act_q),
      .any(act_any),
      .top(act_top)
   );

   assign accept = en_q && !cmd_valid && cand_any && (!act_any || (cand_lvl > act_top));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         act_q     <= '0;
         ack_valid <= 1'b0;
         ack_level <= '0;
      end else begin
         ack_valid <= accept;
         if (accept) begin
            ack_level        <= cand_lvl;
            act_q[cand_lvl]  <= 1'b1;
            en_q             <= 1'b0;
         end else if (cmd_valid) begin
            unique case (cmd)
               CMD_DISABLE: en_q <= 1'b0;
               CMD_ENABLE:  en_q <= 1'b1;
               CMD_SLEEP:   en_q <= 1'b1;
               CMD_RETURN: begin
                  en_q <= 1'b1;
                  if (act_any) act_q[act_top] <= 1'b0;
               end
               default:     en_q <= en_q;
            endcase
         end
      end
   end

   assign irq_en   = en_q;
   assign pending  = pend_q;
   assign active   = act_q;
   assign sleep_ok = (pend_q == '0) && (act_q == '0);
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int NUM_LEVELS = 8,
   localparam int LVL_W = $clog2(NUM_LEVELS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cmd_valid,
   input logic [1:0]            cmd_op,
   input logic                  ack_valid,
   input logic [LVL_W-1:0]      ack_level,
   input logic                  irq_en,
   input logic [NUM_LEVELS-1:0] pending,
   input logic [NUM_LEVELS-1:0] active
);
   // R4: an acknowledge leaves the enable flag clear
   assert_ack_clears_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> !irq_en);

   // R4, R5: the acknowledged level is active and nothing above it is
   assert_ack_top_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> ((active >> ack_level) == NUM_LEVELS'(1)));

   // R6: no acknowledge follows a cycle with the enable flag clear
   assert_no_ack_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(irq_en));

   // R7, R9: pending bits drop only on a return command
   assert_pend_clear_on_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_op == 2'd2) |=> ((pending & $past(pending)) == $past(pending)));

   // R4: at most one level becomes active per cycle
   assert_one_new_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(active & ~$past(active)) <= 1));

   // R7: an active level is always still pending
   assert_active_in_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active & ~pending) == '0);

   // R12: an acknowledge never follows a command cycle
   assert_no_ack_after_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !ack_valid);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_op   (cmd_op),
   .ack_valid(ack_valid),
   .ack_level(ack_level),
   .irq_en   (irq_en),
   .pending  (pending),
   .active   (active)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_strobe = 1'b0;
   logic       cyc_is_io = 1'b0;
   logic [7:0] hw_req = '0;
   logic       swi_we = 1'b0;
   logic [7:0] swi_bits = '0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = '0;
   logic       ack_valid;
   logic [2:0] ack_level;
   logic       irq_en;
   logic [7:0] pending;
   logic [7:0] active;
   logic       sleep_ok;

   int n_cmp = 0;
   int n_bad = 0;
   logic [2:0] exp_q [$];
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_prio_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .cyc_is_io(cyc_is_io),
      .hw_req(hw_req), .swi_we(swi_we), .swi_bits(swi_bits),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .ack_valid(ack_valid),
      .ack_level(ack_level), .irq_en(irq_en), .pending(pending),
      .active(active), .sleep_ok(sleep_ok)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic expect_ack(input logic [2:0] lvl);
      exp_q.push_back(lvl);
   endtask

   task automatic hw_sample(input logic [7:0] req, input logic io);
      hw_req = req; cyc_strobe = 1'b1; cyc_is_io = io;
      tick();
      hw_req = '0; cyc_strobe = 1'b0; cyc_is_io = 1'b0;
   endtask

   task automatic swi_write(input logic [7:0] bits);
      swi_bits = bits; swi_we = 1'b1;
      tick();
      swi_bits = '0; swi_we = 1'b0;
   endtask

   task automatic command(input logic [1:0] op);
      cmd_op = op; cmd_valid = 1'b1;
      tick();
      cmd_valid = 1'b0;
   endtask

   // monitor: every acknowledge is popped from the scoreboard
   always @(negedge clk) begin
      if (rst_n && ack_valid) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R4 unexpected ack actual=%0d expected=none", ack_level);
         end else begin
            logic [2:0] e;
            e = exp_q.pop_front();
            if (ack_level !== e) begin
               n_bad++;
               $display("FAIL R4 ack level actual=%0d expected=%0d", ack_level, e);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      // R1 reset state
      check("R1 irq_en", {7'd0, irq_en}, 8'h00);
      check("R1 pending", pending, 8'h00);
      check("R1 active", active, 8'h00);
      check("R1 sleep_ok", {7'd0, sleep_ok}, 8'h01);
      rst_n = 1'b1;
      tick(2);
      check("R1 ack after reset", {7'd0, ack_valid}, 8'h00);

      // R2, R6: logged while disabled, no ack
      hw_sample(8'h10, 1'b0);
      check("R2 R6 pending logged", pending, 8'h10);
      tick(3);
      check("R6 no service active", active, 8'h00);
      check("R11 sleep_ok low", {7'd0, sleep_ok}, 8'h00);
      // R2: I/O cycle and no strobe are ignored
      hw_sample(8'h01, 1'b1);
      check("R2 io cycle ignored", pending, 8'h10);
      hw_req = 8'h02; tick(); hw_req = '0;
      check("R2 no strobe ignored", pending, 8'h10);

      // R4, R8: enable starts service of level 4
      expect_ack(3'd4);
      command(2'd1);
      check("R8 enable sets flag", {7'd0, irq_en}, 8'h01);
      tick(2);
      check("R4 active set", active, 8'h10);
      check("R4 enable cleared", {7'd0, irq_en}, 8'h00);

      // R3, R5: lower software level waits
      swi_write(8'h04);
      check("R3 swi pending", pending, 8'h14);
      command(2'd1);
      tick(3);
      check("R5 lower level blocked", active, 8'h10);
      // preemption by level 7 from software
      expect_ack(3'd7);
      swi_write(8'h80);
      tick(2);
      check("R3 R4 preempt active", active, 8'h90);

      // R9: request for an already pending level is lost
      hw_sample(8'h80, 1'b0);
      check("R9 pending unchanged", pending, 8'h94);

      // R7: return retires level 7
      command(2'd2);
      check("R7 pending after return", pending, 8'h14);
      check("R7 active after return", active, 8'h10);
      check("R7 enable set", {7'd0, irq_en}, 8'h01);
      tick(2);
      check("R5 level 2 still waits", active, 8'h10);
      // return of level 4 lets level 2 in
      expect_ack(3'd2);
      command(2'd2);
      check("R7 second return pending", pending, 8'h04);
      tick(2);
      check("R4 level 2 active", active, 8'h04);

      // R10: request sampled on the return edge of the same level
      expect_ack(3'd2);
      hw_req = 8'h04; cyc_strobe = 1'b1; cmd_op = 2'd2; cmd_valid = 1'b1;
      tick();
      hw_req = '0; cyc_strobe = 1'b0; cmd_valid = 1'b0;
      check("R10 pending kept", pending, 8'h04);
      check("R10 active cleared", active, 8'h00);
      tick(2);
      check("R10 reacknowledged", active, 8'h04);
      command(2'd2);
      check("R11 sleep_ok idle", {7'd0, sleep_ok}, 8'h01);

      // R8: disable then sleep
      command(2'd0);
      check("R8 disable clears", {7'd0, irq_en}, 8'h00);
      command(2'd3);
      check("R8 sleep sets", {7'd0, irq_en}, 8'h01);

      // R12: commands hold off acceptance
      command(2'd0);
      swi_write(8'h02);
      cmd_op = 2'd1; cmd_valid = 1'b1;
      tick(3);
      check("R12 no accept during commands", active, 8'h00);
      expect_ack(3'd1);
      cmd_valid = 1'b0;
      tick(2);
      check("R12 accepted after commands", active, 8'h02);
      command(2'd2);

      // R4: several levels at once, highest first
      expect_ack(3'd5);
      expect_ack(3'd3);
      expect_ack(3'd1);
      hw_sample(8'h2A, 1'b0);
      check("R2 multi pending", pending, 8'h2A);
      tick(2);
      check("R4 highest taken", active, 8'h20);
      command(2'd2);
      tick(2);
      check("R4 next highest", active, 8'h08);
      command(2'd2);
      tick(2);
      check("R4 last level", active, 8'h02);
      command(2'd2);
      tick(2);
      check("R11 idle at end", {7'd0, sleep_ok}, 8'h01);
      check("R4 scoreboard drained", 8'(exp_q.size()), 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule